// File: doc/BRIEF.md
# Transmit FIFO Flag and Interrupt Controller

This block keeps the transmit-side status of a low-power serial transmitter that has a small character queue. Software writes characters into the queue through a write strobe. The loader that feeds the serial shifter takes the oldest character with a pop strobe. The block keeps the queue occupancy and derives four status flags from it: holding slot free, queue has room, queue drained, and fill level reached.

Each flag has its own enable bit. One registered line goes to the general interrupt controller. A second registered line requests wakeup from a low-power state, and only the drained and fill-level flags may drive it. A flush strobe discards the whole queue at once. A sticky bit records writes that were lost because the queue was full.

Top module: `txfifo_irq_ctrl`

## Requirements
- R1: After reset the level is 0, `flag_tde`, `flag_nf` and `flag_emp` are 1, `flag_thr` equals (`thresh` == 0), and `ovf_sticky`, `irq` and `wkup` are 0.
- R2: Characters leave in the order they were written. While the level is nonzero, `pop_data` shows the oldest stored character.
- R3: A write in a cycle where the queue is full and no pop is accepted is discarded. It sets `ovf_sticky`, which then stays 1 until reset. A write together with a pop on a full queue is accepted.
- R4: A pop while the level is 0 is ignored, and the level stays 0.
- R5: `flag_tde` goes to 0 after an accepted write. It goes to 1 after a pop that is accepted without a write in the same cycle, and it goes to 1 after a flush.
- R6: `flag_nf` is 0 exactly while the level equals DEPTH.
- R7: `flag_emp` is 1 only while the level is 0. It is forced to 0 during any cycle in which `flush_req` is high.
- R8: On the clock edge where `flush_req` is high, the level becomes 0 and any write or pop in that cycle is discarded. Such a discarded write does not set `ovf_sticky`.
- R9: `flag_thr` is 1 exactly while the level is greater than or equal to `thresh`. It is re-evaluated every cycle.
- R10: `irq` is a register. At each clock edge it loads the OR of (flag AND enable) over all four flags. The enable bits are 0 for holding slot free, 1 for room, 2 for drained and 3 for fill level.
- R11: `wkup` is a register. At each clock edge it loads the OR of (flag AND enable) over the drained flag (bit 2) and the fill-level flag (bit 3) only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Character write strobe from software |
| wr_data | input | DW | Character to enqueue |
| pop_en | input | 1 | Pop strobe from the shift loader |
| pop_data | output | DW | Oldest queued character |
| thresh | input | CW | Fill-level threshold, 0..DEPTH |
| irq_en | input | 4 | Per-flag enables (see R10) |
| flush_req | input | 1 | Discard the queue contents |
| level | output | CW | Current occupancy |
| flag_tde | output | 1 | Holding slot free |
| flag_nf | output | 1 | Queue has room |
| flag_emp | output | 1 | Queue drained |
| flag_thr | output | 1 | Fill level reached |
| ovf_sticky | output | 1 | A write was lost because the queue was full |
| irq | output | 1 | General interrupt request |
| wkup | output | 1 | Low-power wakeup request |

## Verification
The hardest conditions to reach are the boundary collisions. One is a write and a pop on the same edge while the queue is full, which must be accepted without overflow. The other is a flush that arrives together with a write, which must be discarded without overflow. The stimulus first fills the queue past DEPTH to reach these corners on purpose. It then sweeps the threshold across every level and ends with a long random mix of strobes, enables and thresholds. A behavioural queue model is compared against every output on every cycle.

// File: rtl/txfifo_irq_pkg.sv
package txfifo_irq_pkg;
  localparam int FLG_TDE = 0;
  localparam int FLG_NF  = 1;
  localparam int FLG_EMP = 2;
  localparam int FLG_THR = 3;
  localparam int NFLG    = 4;
  localparam logic [NFLG-1:0] WAKE_MASK = 4'b1100;

  function automatic logic any_req(input logic [NFLG-1:0] flg,
                                   input logic [NFLG-1:0] en,
                                   input logic [NFLG-1:0] mask);
    return |(flg & en & mask);
  endfunction

  function automatic logic level_met(input int unsigned lvl, input int unsigned thr);
    return lvl >= thr;
  endfunction
endpackage

// File: rtl/txfifo_store.sv
module txfifo_store #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int AW    = 3,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          pop_en,
  input  logic          flush,
  output logic          wr_acc,
  output logic          pop_acc,
  output logic          wr_drop,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] level
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic full, empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign pop_acc = pop_en && !empty && !flush;
  assign wr_acc  = wr_en && !flush && (!full || pop_acc);
  assign wr_drop = wr_en && !flush && full && !pop_acc;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (wr_acc)  wp <= bump(wp);
      if (pop_acc) rp <= bump(rp);
      case ({wr_acc, pop_acc})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/txfifo_flags.sv
module txfifo_flags
  import txfifo_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   level,
  input  logic [CW-1:0]   thresh,
  input  logic            flush,
  input  logic            wr_acc,
  input  logic            pop_acc,
  input  logic            wr_drop,
  output logic [NFLG-1:0] flags,
  output logic            ovf
);
  logic tde_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tde_q <= 1'b1;
      ovf   <= 1'b0;
    end else begin
      if (flush)        tde_q <= 1'b1;
      else if (wr_acc)  tde_q <= 1'b0;
      else if (pop_acc) tde_q <= 1'b1;
      if (wr_drop) ovf <= 1'b1;
    end
  end

  always_comb begin
    flags          = '0;
    flags[FLG_TDE] = tde_q;
    flags[FLG_NF]  = (level != CW'(DEPTH));
    flags[FLG_EMP] = (level == '0) && !flush;
    flags[FLG_THR] = level_met(int'(level), int'(thresh));
  end
endmodule

// File: rtl/txfifo_irq_out.sv
module txfifo_irq_out
  import txfifo_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NFLG-1:0] flags,
  input  logic [NFLG-1:0] en,
  output logic            irq,
  output logic            wkup
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq  <= 1'b0;
      wkup <= 1'b0;
    end else begin
      irq  <= any_req(flags, en, '1);
      wkup <= any_req(flags, en, WAKE_MASK);
    end
  end
endmodule

// File: rtl/txfifo_irq_ctrl.sv
module txfifo_irq_ctrl
  import txfifo_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          pop_en,
  output logic [DW-1:0] pop_data,
  input  logic [CW-1:0] thresh,
  input  logic [3:0]    irq_en,
  input  logic          flush_req,
  output logic [CW-1:0] level,
  output logic          flag_tde,
  output logic          flag_nf,
  output logic          flag_emp,
  output logic          flag_thr,
  output logic          ovf_sticky,
  output logic          irq,
  output logic          wkup
);
  logic            wr_acc, pop_acc, wr_drop;
  logic [NFLG-1:0] flags;

  txfifo_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .pop_en(pop_en), .flush(flush_req), .wr_acc(wr_acc), .pop_acc(pop_acc),
    .wr_drop(wr_drop), .rd_data(pop_data), .level(level)
  );

  txfifo_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
    .clk(clk), .rst_n(rst_n), .level(level), .thresh(thresh),
    .flush(flush_req), .wr_acc(wr_acc), .pop_acc(pop_acc),
    .wr_drop(wr_drop), .flags(flags), .ovf(ovf_sticky)
  );

  txfifo_irq_out u_out (
    .clk(clk), .rst_n(rst_n), .flags(flags), .en(irq_en),
    .irq(irq), .wkup(wkup)
  );

  assign flag_tde = flags[FLG_TDE];
  assign flag_nf  = flags[FLG_NF];
  assign flag_emp = flags[FLG_EMP];
  assign flag_thr = flags[FLG_THR];
endmodule

// File: rtl/txfifo_irq_chk.sv
module txfifo_irq_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          pop_en,
  input logic          flush_req,
  input logic [3:0]    irq_en,
  input logic [CW-1:0] level,
  input logic          wr_acc,
  input logic          flag_tde,
  input logic          flag_nf,
  input logic          flag_emp,
  input logic          flag_thr,
  input logic          ovf_sticky,
  input logic          irq,
  input logic          wkup
);
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (level == CW'(DEPTH) && wr_en && !pop_en && !flush_req) |=> (level == CW'(DEPTH) && ovf_sticky)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_sticky |=> ovf_sticky); // R3
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && pop_en && !wr_en) |=> (level == '0)); // R4
  AST_TDE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> !flag_tde); // R5
  AST_EMP_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    flag_emp |-> flag_nf); // R6
  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (level == '0 && flag_tde)); // R8
  AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (|({flag_thr, flag_emp, flag_nf, flag_tde} & irq_en)) |=> irq); // R10
  AST_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en[3:2] == 2'b00) |=> !wkup); // R11
endmodule

bind txfifo_irq_ctrl txfifo_irq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .pop_en(pop_en),
  .flush_req(flush_req), .irq_en(irq_en), .level(level), .wr_acc(wr_acc),
  .flag_tde(flag_tde), .flag_nf(flag_nf), .flag_emp(flag_emp),
  .flag_thr(flag_thr), .ovf_sticky(ovf_sticky), .irq(irq), .wkup(wkup)
);

// File: tb/txfifo_irq_ctrl_test.sv
module txfifo_irq_ctrl_test;
  localparam int DEPTH = 8;
  localparam int DW    = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, pop_en = 0, flush_req = 0;
  logic [DW-1:0] wr_data = '0;
  logic [CW-1:0] thresh = CW'(4);
  logic [3:0] irq_en = '0;
  logic [DW-1:0] pop_data;
  logic [CW-1:0] level;
  logic flag_tde, flag_nf, flag_emp, flag_thr, ovf_sticky, irq, wkup;

  txfifo_irq_ctrl #(.DEPTH(DEPTH), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .pop_en(pop_en), .pop_data(pop_data), .thresh(thresh), .irq_en(irq_en),
    .flush_req(flush_req), .level(level), .flag_tde(flag_tde),
    .flag_nf(flag_nf), .flag_emp(flag_emp), .flag_thr(flag_thr),
    .ovf_sticky(ovf_sticky), .irq(irq), .wkup(wkup)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state
  int q[$];
  bit m_tde = 1, m_ovf = 0, m_irq = 0, m_wk = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] mflags();
    logic [3:0] f;
    f[0] = m_tde;
    f[1] = (q.size() < DEPTH);
    f[2] = (q.size() == 0) && !flush_req;
    f[3] = (q.size() >= int'(thresh));
    return f;
  endfunction

  always begin
    @(posedge clk);
    if (!rst_n) begin
      q.delete(); m_tde = 1; m_ovf = 0; m_irq = 0; m_wk = 0;
    end else begin
      logic [3:0] f;
      bit pok, wok;
      f = mflags();
      m_irq = |(f & irq_en);
      m_wk  = |(f & irq_en & 4'b1100);
      if (flush_req) begin
        q.delete(); m_tde = 1;
      end else begin
        pok = pop_en && q.size() > 0;
        wok = wr_en && (q.size() < DEPTH || pok);
        if (wr_en && !wok) m_ovf = 1;
        if (pok) void'(q.pop_front());
        if (wok) q.push_back(int'(wr_data));
        if (wok) m_tde = 0; else if (pok) m_tde = 1;
      end
    end
    #2;
    if (rst_n && !done) begin
      logic [3:0] f;
      f = mflags();
      chk("R2 level", int'(level), q.size());
      if (q.size() > 0) chk("R2 pop_data order", int'(pop_data), q[0]);
      chk("R5 flag_tde", flag_tde, f[0]);
      chk("R6 flag_nf", flag_nf, f[1]);
      chk("R7 flag_emp", flag_emp, f[2]);
      chk("R9 flag_thr", flag_thr, f[3]);
      chk("R3 ovf_sticky", ovf_sticky, m_ovf);
      chk("R10 irq", irq, m_irq);
      chk("R11 wkup", wkup, m_wk);
    end
  end

  task automatic drive(input bit w, input int d, input bit p, input bit f);
    @(negedge clk);
    wr_en = w; wr_data = DW'(d); pop_en = p; flush_req = f;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 level", int'(level), 0);
    chk("R1 flag_tde", flag_tde, 1);
    chk("R1 flag_nf", flag_nf, 1);
    chk("R1 flag_emp", flag_emp, 1);
    chk("R1 flag_thr", flag_thr, 0);
    chk("R1 ovf", ovf_sticky, 0);
    chk("R1 irq", irq, 0);
    chk("R1 wkup", wkup, 0);
    rst_n = 1;
    // fill past full: R3 overflow, R6 not-full, R10 irq with tde/nf enables
    irq_en = 4'b0011;
    for (int i = 0; i < DEPTH + 2; i++) drive(1, 16 + i, 0, 0);
    drive(1, 99, 1, 0);           // R3 write with pop on full queue accepted
    drive(0, 0, 0, 0);
    // drain past empty: R4, R11 wake via empty/threshold
    irq_en = 4'b1100; thresh = CW'(3);
    for (int i = 0; i < DEPTH + 3; i++) drive(0, 0, 1, 0);
    drive(0, 0, 0, 0);
    // threshold sweep: R9
    for (int t = 0; t <= DEPTH; t++) begin
      thresh = CW'(t);
      drive(1, 40 + t, 0, 0);
      drive(0, 0, 0, 0);
    end
    // flush with simultaneous write: R8, R7
    drive(1, 7, 1, 1);
    drive(0, 0, 0, 0);
    drive(1, 8, 0, 0);
    drive(0, 0, 1, 0);
    // random mix
    for (int i = 0; i < 600; i++) begin
      if (i % 37 == 0) irq_en = 4'($urandom);
      if (i % 23 == 0) thresh = CW'($urandom_range(0, DEPTH));
      drive(($urandom % 3) != 0, int'($urandom % 256), ($urandom % 3) == 0,
            ($urandom % 50) == 0);
    end
    drive(0, 0, 0, 0);
    drive(0, 0, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule